// File: doc/BRIEF.md
# PC Card Attribute Configuration Registers

This block serves the attribute-memory byte space of a removable storage card. Even byte addresses below a configurable register base return bytes from the card information ROM, whose contents arrive as a parameter. At the base sit four byte-wide registers:

- mode/option, at offset 0x0
- status, at offset 0x2
- pin replacement, at offset 0x4
- socket/copy, at offset 0x6, which is always zero

A host writes the option register to pick the addressing mode and to request a whole-card soft reset. It uses the status register for power-down control and to see the pending interrupt. The block also drives the card's interrupt line, which is active-high here. The line is asserted only when nothing is pending, the device-control interrupt-disable and reset inputs are both low, and no soft reset is in progress.

Read data is combinational from the address. Writes take effect at the rising clock edge while `attr_wr` is high. A small two-state machine controls the soft reset. In state CS_RUN, registers accept writes and the pending bit samples the task-file request every cycle. The transition CS_RUN to CS_RESET fires on an option write with bit 7 set. CS_RESET lasts exactly one cycle, raises the reset request and ignores writes. The transition CS_RESET to CS_RUN clears the option, status and pin registers.

Top module: `pccard_cfg_regs`

## Requirements
- R1: After reset, the option, status and pin registers are zero, so the addressing mode is 0 (memory mapped), status reads 0x00 and the pin register reads 0x0C.
- R2: For an address below the base, an even address below the ROM length returns ROM byte [address]; odd addresses and addresses at or beyond the ROM length return 0x00; writes below the base change nothing.
- R3: Offset 0x6 and every other offset at or above the base that is not 0x0, 0x2 or 0x4 reads 0x00, and writes to them change nothing.
- R4: An option write stores the written byte ANDed with 0xCF. `addr_mode` shows option bits [5:0], and bit 6 (level request) reads back.
- R5: An option write with bit 7 set moves the state machine to CS_RESET for exactly one cycle. In that cycle `card_rst_req` is high, the option register reads back with bit 7 set, and writes are ignored. Afterwards the option, status and pin registers are all zero.
- R6: A status write keeps the current bits 7 and 1 (mask 0x82) and loads bits 6, 5, 4 and 2 (mask 0x74) from the written byte.
- R7: A status write whose bit 2 (power-down) differs from the stored bit 2 sets the ready bit (bit 5) of the pin register. That bit stays set until a reset.
- R8: The pin register reads as its ready bit (bit 5) ORed with 0x0C. A pin write cannot change the ready bit and stores only bit 1 of the written byte.
- R9: In CS_RUN, status bit 1 (pending) takes the level of `tf_irq` at each rising edge.
- R10: A status read returns the stored status with bit 1 forced to 0 while `dc_irq_dis` is high, and unchanged otherwise.
- R11: `card_irq` is high exactly when status bit 1, `dc_irq_dis`, `dc_soft_rst` and option bit 7 are all low. It responds combinationally to all four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| attr_addr | input | ADDR_W (10) | Attribute byte address |
| attr_wr | input | 1 | Write strobe for the addressed byte |
| attr_wdata | input | 8 | Write data |
| attr_rdata | output | 8 | Combinational read data for `attr_addr` |
| tf_irq | input | 1 | Task-file interrupt request level |
| dc_irq_dis | input | 1 | Device-control interrupt-disable bit |
| dc_soft_rst | input | 1 | Device-control soft-reset bit |
| card_rst_req | output | 1 | Whole-card soft-reset request, high in CS_RESET |
| addr_mode | output | 6 | Current addressing-mode field |
| card_irq | output | 1 | Card interrupt line |

## Verification
The assertions check several properties on every clock:

- the pending bit tracks the request in CS_RUN
- CS_RESET lasts a single cycle and always leaves the registers cleared
- stored option bits 5:4 are always zero after a write
- a power-down toggle always sets the ready bit
- pin writes never touch the ready bit
- the interrupt is low whenever one of its blocking terms is high

Other behaviour only shows in the bench's scenarios: the read-back values of each address region, the interrupt-bit masking on status reads, and the exact cycle at which a soft reset becomes visible.

// File: rtl/pccard_cfg_pkg.sv
package pccard_cfg_pkg;

    typedef enum logic [0:0] {
        CS_RUN   = 1'b0,
        CS_RESET = 1'b1
    } card_state_e;

    localparam logic [7:0] OPT_WMASK  = 8'hCF;
    localparam int         OPT_SRST   = 7;
    localparam int         MODE_W     = 6;

    localparam logic [7:0] STAT_KEEP  = 8'h82;
    localparam logic [7:0] STAT_LOAD  = 8'h74;
    localparam int         STAT_PEND  = 1;
    localparam int         STAT_PWRDN = 2;

    localparam int         PIN_READY  = 5;
    localparam int         PIN_MRDY   = 1;
    localparam logic [7:0] PIN_FIXED  = 8'h0C;

endpackage

// File: rtl/pccard_cis_rom.sv
module pccard_cis_rom #(
    parameter int ADDR_W  = 10,
    parameter int ROM_LEN = 16,
    parameter logic [ROM_LEN*8-1:0] ROM_DATA = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        rom_byte
);
    localparam int IDX_W = (ROM_LEN > 1) ? $clog2(ROM_LEN) : 1;
    localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(ROM_LEN);

    logic [7:0] bytes_w [ROM_LEN];

    for (genvar gi = 0; gi < ROM_LEN; gi++) begin : g_byte
        assign bytes_w[gi] = ROM_DATA[gi*8 +: 8];
    end

    logic in_range;
    assign in_range = ({1'b0, addr} < ROM_LIM) && !addr[0];

    always_comb begin
        rom_byte = 8'h00;
        if (in_range) rom_byte = bytes_w[addr[IDX_W-1:0]];
    end
endmodule

// File: rtl/pccard_attr_decode.sv
module pccard_attr_decode #(
    parameter int ADDR_W    = 10,
    parameter int ATTR_BASE = 'h200
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_rom,
    output logic              sel_opt,
    output logic              sel_stat,
    output logic              sel_pin
);
    localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(ATTR_BASE);

    logic [ADDR_W-1:0] off;
    logic              in_regs;

    always_comb begin
        in_regs  = (addr >= BASE_W);
        off      = addr - BASE_W;
        sel_rom  = !in_regs;
        sel_opt  = in_regs && (off == ADDR_W'(0));
        sel_stat = in_regs && (off == ADDR_W'(2));
        sel_pin  = in_regs && (off == ADDR_W'(4));
    end
endmodule

// File: rtl/pccard_irq_gen.sv
module pccard_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic dc_irq_dis,
    input  logic dc_soft_rst,
    input  logic opt_srst,
    output logic card_irq
);
    always_comb begin
        card_irq = 1'b1;
        if (pend)        card_irq = 1'b0;
        if (dc_irq_dis)  card_irq = 1'b0;
        if (dc_soft_rst) card_irq = 1'b0;
        if (opt_srst)    card_irq = 1'b0;
    end

    // R11: any blocking term keeps the line low
    assert_irq_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend || dc_irq_dis || dc_soft_rst || opt_srst) |-> !card_irq);
endmodule

// File: rtl/pccard_cfg_core.sv
module pccard_cfg_core
    import pccard_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_rom,
    input  logic        sel_opt,
    input  logic        sel_stat,
    input  logic        sel_pin,
    input  logic [7:0]  rom_byte,
    input  logic        attr_wr,
    input  logic [7:0]  attr_wdata,
    input  logic        tf_irq,
    input  logic        dc_irq_dis,
    output logic [7:0]  attr_rdata,
    output logic        card_rst_req,
    output logic [MODE_W-1:0] addr_mode,
    output logic        pend,
    output logic        opt_srst
);
    card_state_e state_q, state_d;
    logic [7:0]  opt_q, stat_q, pins_q;
    logic [7:0]  stat_d, pins_d;
    logic        opt_wr, stat_wr, pin_wr, pwr_toggle;

    assign opt_wr     = attr_wr && sel_opt  && (state_q == CS_RUN);
    assign stat_wr    = attr_wr && sel_stat && (state_q == CS_RUN);
    assign pin_wr     = attr_wr && sel_pin  && (state_q == CS_RUN);
    assign pwr_toggle = stat_q[STAT_PWRDN] ^ attr_wdata[STAT_PWRDN];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_RUN:   if (opt_wr && attr_wdata[OPT_SRST]) state_d = CS_RESET;
            CS_RESET: state_d = CS_RUN;
        endcase
    end

    // next register values in CS_RUN
    always_comb begin
        stat_d = stat_q;
        pins_d = pins_q;
        if (stat_wr) begin
            stat_d = (stat_q & STAT_KEEP) | (attr_wdata & STAT_LOAD);
            if (pwr_toggle) pins_d[PIN_READY] = 1'b1;
        end
        if (pin_wr) begin
            pins_d           = pins_q & (8'h1 << PIN_READY);
            pins_d[PIN_MRDY] = attr_wdata[PIN_MRDY];
        end
        stat_d[STAT_PEND] = tf_irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q  <= 8'h00;
            stat_q <= 8'h00;
            pins_q <= 8'h00;
        end else begin
            unique case (state_q)
                CS_RUN: begin
                    if (opt_wr) opt_q <= attr_wdata & OPT_WMASK;
                    stat_q <= stat_d;
                    pins_q <= pins_d;
                end
                CS_RESET: begin
                    opt_q  <= 8'h00;
                    stat_q <= 8'h00;
                    pins_q <= 8'h00;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        card_rst_req = (state_q == CS_RESET);
        addr_mode    = opt_q[MODE_W-1:0];
        pend         = stat_q[STAT_PEND];
        opt_srst     = opt_q[OPT_SRST];
        attr_rdata   = 8'h00;
        if (sel_rom) begin
            attr_rdata = rom_byte;
        end else if (sel_opt) begin
            attr_rdata = opt_q;
        end else if (sel_stat) begin
            attr_rdata = stat_q;
            if (dc_irq_dis) attr_rdata[STAT_PEND] = 1'b0;
        end else if (sel_pin) begin
            attr_rdata = (pins_q & (8'h1 << PIN_READY)) | PIN_FIXED;
        end
    end

    // R9: pending bit samples the request while running
    assert_pend_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && state_q == CS_RUN && $past(state_q) == CS_RUN)
            |-> stat_q[STAT_PEND] == $past(tf_irq));

    // R5: reset state lasts one cycle and clears everything
    assert_reset_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_RESET) |=> (state_q == CS_RUN && opt_q == 8'h00
                                   && stat_q == 8'h00 && pins_q == 8'h00));

    assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_req |=> !card_rst_req);

    // R4: masked option bits never stored
    assert_opt_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        opt_wr |=> (opt_q & 8'h30) == 8'h00);

    // R7: power-down toggle sets ready
    assert_ready_on_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && pwr_toggle) |=> pins_q[PIN_READY]);

    // R8: pin write keeps ready and stores bit 1
    assert_pin_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_wr |=> (pins_q[PIN_READY] == $past(pins_q[PIN_READY])
                    && pins_q[PIN_MRDY] == $past(attr_wdata[PIN_MRDY])));
endmodule

// File: rtl/pccard_cfg_regs.sv
module pccard_cfg_regs
    import pccard_cfg_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int ATTR_BASE = 'h200,
    parameter int ROM_LEN   = 16,
    parameter logic [ROM_LEN*8-1:0] ROM_DATA = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] attr_addr,
    input  logic              attr_wr,
    input  logic [7:0]        attr_wdata,
    output logic [7:0]        attr_rdata,
    input  logic              tf_irq,
    input  logic              dc_irq_dis,
    input  logic              dc_soft_rst,
    output logic              card_rst_req,
    output logic [5:0]        addr_mode,
    output logic              card_irq
);
    logic       sel_rom, sel_opt, sel_stat, sel_pin;
    logic [7:0] rom_byte;
    logic       pend, opt_srst;

    pccard_attr_decode #(.ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE)) u_dec (
        .addr(attr_addr), .sel_rom(sel_rom), .sel_opt(sel_opt),
        .sel_stat(sel_stat), .sel_pin(sel_pin)
    );

    pccard_cis_rom #(.ADDR_W(ADDR_W), .ROM_LEN(ROM_LEN), .ROM_DATA(ROM_DATA)) u_rom (
        .addr(attr_addr), .rom_byte(rom_byte)
    );

    pccard_cfg_core u_core (
        .clk(clk), .rst_n(rst_n),
        .sel_rom(sel_rom), .sel_opt(sel_opt), .sel_stat(sel_stat), .sel_pin(sel_pin),
        .rom_byte(rom_byte), .attr_wr(attr_wr), .attr_wdata(attr_wdata),
        .tf_irq(tf_irq), .dc_irq_dis(dc_irq_dis),
        .attr_rdata(attr_rdata), .card_rst_req(card_rst_req),
        .addr_mode(addr_mode), .pend(pend), .opt_srst(opt_srst)
    );

    pccard_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .pend(pend), .dc_irq_dis(dc_irq_dis),
        .dc_soft_rst(dc_soft_rst), .opt_srst(opt_srst), .card_irq(card_irq)
    );
endmodule

// File: tb/pccard_cfg_regs_tb.sv
module pccard_cfg_regs_tb;
    localparam int AW = 10;
    localparam int BASE = 'h200;
    localparam int RLEN = 16;
    localparam logic [RLEN*8-1:0] RDATA = 128'h8899AABBCCDDEEFF0123456789ABCDEF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] attr_addr = '0;
    logic          attr_wr = 1'b0;
    logic [7:0]    attr_wdata = 8'h00;
    logic [7:0]    attr_rdata;
    logic          tf_irq = 1'b0, dc_irq_dis = 1'b0, dc_soft_rst = 1'b0;
    logic          card_rst_req, card_irq;
    logic [5:0]    addr_mode;

    int checks = 0, fails = 0;
    bit done = 0;

    // model state
    logic [7:0] m_opt = 0, m_stat = 0, m_pins = 0;
    bit         m_busy = 0;

    always #5 clk = ~clk;

    pccard_cfg_regs #(.ADDR_W(AW), .ATTR_BASE(BASE), .ROM_LEN(RLEN), .ROM_DATA(RDATA)) u_dut (
        .clk(clk), .rst_n(rst_n), .attr_addr(attr_addr), .attr_wr(attr_wr),
        .attr_wdata(attr_wdata), .attr_rdata(attr_rdata), .tf_irq(tf_irq),
        .dc_irq_dis(dc_irq_dis), .dc_soft_rst(dc_soft_rst),
        .card_rst_req(card_rst_req), .addr_mode(addr_mode), .card_irq(card_irq)
    );

    function automatic logic [7:0] exp_read(input logic [AW-1:0] a, input logic ni);
        int off;
        if (a < BASE) begin
            if (a[0] == 1'b0 && a < RLEN) return RDATA[a*8 +: 8];
            return 8'h00;
        end
        off = int'(a) - BASE;
        case (off)
            0: return m_opt;
            2: return ni ? (m_stat & 8'hFD) : m_stat;
            4: return (m_pins & 8'h20) | 8'h0C;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string region_tag(input logic [AW-1:0] a);
        int off;
        if (a < BASE) return "R2";
        off = int'(a) - BASE;
        case (off)
            0: return "R4";
            2: return "R6";
            4: return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%02h expected=%02h", tag, $time, act, exp);
        end
    endtask

    task automatic model_step(input logic [AW-1:0] a, input logic w,
                              input logic [7:0] d, input logic ti);
        int off;
        if (m_busy) begin
            m_opt = 0; m_stat = 0; m_pins = 0; m_busy = 0;
            return;
        end
        off = int'(a) - BASE;
        if (w && a >= BASE) begin
            if (off == 0) begin
                m_opt = d & 8'hCF;
                if (d[7]) m_busy = 1;
            end else if (off == 2) begin
                if (m_stat[2] != d[2]) m_pins[5] = 1'b1;
                m_stat = (m_stat & 8'h82) | (d & 8'h74);
            end else if (off == 4) begin
                m_pins = (m_pins & 8'h20) | (d & 8'h02);
            end
        end
        m_stat[1] = ti;
    endtask

    task automatic cyc(input logic [AW-1:0] a, input logic w, input logic [7:0] d,
                       input logic ti, input logic ni, input logic si, input string tag);
        logic exp_irq;
        @(negedge clk);
        attr_addr = a; attr_wr = w; attr_wdata = d;
        tf_irq = ti; dc_irq_dis = ni; dc_soft_rst = si;
        #1;
        check(tag, attr_rdata, exp_read(a, ni));
        exp_irq = !m_stat[1] && !ni && !si && !m_opt[7];
        check("R11", {7'd0, card_irq}, {7'd0, exp_irq});
        check("R5", {7'd0, card_rst_req}, {7'd0, m_busy});
        check("R4", {2'd0, addr_mode}, {2'd0, m_opt[5:0]});
        model_step(a, w, d, ti);
    endtask

    function automatic logic [AW-1:0] ra(input int off);
        return AW'(BASE + off);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset values
        cyc(ra(0), 0, 0, 0, 0, 0, "R1");
        cyc(ra(2), 0, 0, 0, 0, 0, "R1");
        cyc(ra(4), 0, 0, 0, 0, 0, "R1");
        // R2: ROM region
        cyc(0, 0, 0, 0, 0, 0, "R2");
        cyc(2, 0, 0, 0, 0, 0, "R2");
        cyc(14, 0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, 0, "R2");
        cyc(16, 0, 0, 0, 0, 0, "R2");
        cyc(AW'(BASE - 2), 0, 0, 0, 0, 0, "R2");
        cyc(4, 1, 8'h55, 0, 0, 0, "R2");
        cyc(4, 0, 0, 0, 0, 0, "R2");
        // R3: socket/copy and unmapped offsets
        cyc(ra(6), 1, 8'hFF, 0, 0, 0, "R3");
        cyc(ra(6), 0, 0, 0, 0, 0, "R3");
        cyc(ra(8), 1, 8'hFF, 0, 0, 0, "R3");
        cyc(ra(1), 0, 0, 0, 0, 0, "R3");
        // R4: option mask and mode
        cyc(ra(0), 1, 8'h7F, 0, 0, 0, "R4");
        cyc(ra(0), 0, 0, 0, 0, 0, "R4");
        cyc(ra(0), 1, 8'h43, 0, 0, 0, "R4");
        cyc(ra(0), 0, 0, 0, 0, 0, "R4");
        // R6 / R7: status write and ready bit
        cyc(ra(2), 1, 8'hFF, 0, 0, 0, "R6");
        cyc(ra(2), 0, 0, 0, 0, 0, "R6");
        cyc(ra(4), 0, 0, 0, 0, 0, "R7");
        cyc(ra(2), 1, 8'h04, 0, 0, 0, "R6");
        cyc(ra(2), 1, 8'h00, 0, 0, 0, "R7");
        cyc(ra(4), 0, 0, 0, 0, 0, "R7");
        // R8: pin write cannot clear ready
        cyc(ra(4), 1, 8'h00, 0, 0, 0, "R8");
        cyc(ra(4), 1, 8'hFF, 0, 0, 0, "R8");
        cyc(ra(4), 0, 0, 0, 0, 0, "R8");
        // R9 / R10 / R11: pending, masking, interrupt line
        cyc(ra(2), 0, 0, 1, 0, 0, "R9");
        cyc(ra(2), 0, 0, 1, 0, 0, "R9");
        cyc(ra(2), 0, 0, 1, 1, 0, "R10");
        cyc(ra(2), 0, 0, 0, 1, 0, "R10");
        cyc(ra(2), 0, 0, 0, 0, 1, "R11");
        cyc(ra(2), 0, 0, 0, 0, 0, "R11");
        // R5: soft reset sequence, write in the reset cycle ignored
        cyc(ra(2), 1, 8'h14, 1, 0, 0, "R5");
        cyc(ra(0), 1, 8'h85, 1, 0, 0, "R5");
        cyc(ra(0), 1, 8'h3F, 1, 0, 0, "R5");
        cyc(ra(0), 0, 0, 1, 0, 0, "R5");
        cyc(ra(2), 0, 0, 1, 0, 0, "R5");
        cyc(ra(4), 0, 0, 0, 0, 0, "R5");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            int sel;
            sel = int'($urandom % 4);
            if (sel == 0)      a = AW'($urandom % 32);
            else if (sel == 3) a = AW'($urandom);
            else               a = ra(int'($urandom % 8));
            cyc(a, ($urandom % 3) == 0, 8'($urandom), ($urandom % 4) == 0,
                ($urandom % 4) == 0, ($urandom % 6) == 0, region_tag(a));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule